// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers event pulses from up to sixteen DMA channels and sorts them into four interrupt classes: chain-end completion, per-node completion, and two independent error sources. Each class keeps a sticky raw latch per channel, an enable-high mask, and a masked view (raw AND mask). A summary view gives, for each channel, the OR of its four masked bits. A single registered interrupt line is high while any summary bit is set.

Software reaches the block through a plain register bus. It writes masks, clears raw bits by writing ones, and reads the masked, summary and raw views. Two more registers are also visible on the bus: a read-only channel-busy vector taken straight from the channel engines, and a read/write channel priority word. A channel that is being shut down should have its bit cleared in all four raw latches. The channel datapaths themselves sit outside this block.

Top module: `dmairq_aggr`

## Requirements
- R1: A pulse on a class event input sets the matching raw bit (bit n = channel n) on the next clock edge whatever the mask holds. The bit then stays set until cleared. No raw bit sets without an event.
- R2: A bus write to a raw latch clears exactly the bits written as 1 and leaves the bits written as 0. The raw latches sit at 0x600 (chain), 0x608 (node), 0x610 (error A) and 0x618 (error B).
- R3: If an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R4: The masked views at 0x004 (chain), 0x008 (node), 0x00C (error A) and 0x010 (error B) read as raw AND mask for their class.
- R5: The masks at 0x018, 0x01C, 0x020 and 0x024 store the low 16 bits of a write (1 = enabled) and read back zero-extended. A mask changes only when its own address is written.
- R6: The summary view at 0x000 reads bit n as the OR of channel n's four masked bits.
- R7: irq_o rises one clock after the summary becomes non-zero and falls one clock after it becomes zero.
- R8: Address 0x690 reads the live ch_busy_i vector. Address 0x688 is a 32-bit priority word that reads back what was last written.
- R9: After reset, all raw latches, masks, the priority word and irq_o are zero.
- R10: Unmapped addresses read as zero. Writes to unmapped or read-only addresses change no state.
- R11: The classes are independent: an event in one class sets no bit in any other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_chain_i | input | NCH | Chain-end completion pulses, one per channel |
| evt_node_i | input | NCH | Node completion pulses, one per channel |
| evt_fault0_i | input | NCH | Error source A pulses |
| evt_fault1_i | input | NCH | Error source B pulses |
| ch_busy_i | input | NCH | Running-channel vector from the engines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A corrupted raw or mask bit appears on the masked and summary reads in the same cycle as the bad state. It reaches irq_o exactly one clock later. A clear that hits the wrong bit or class leaves a neighbouring bit changed, and the per-bit sweep reads that back at once. A lost set-over-clear priority shows up as a zero read right after the colliding cycle. Decode faults show as wrong data at the addresses next to the intended one, or as state changing after a write to a read-only address.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NCLASS = 4;
  localparam int ADDR_W = 12;

  typedef enum int {CL_CHAIN = 0, CL_NODE = 1, CL_FAULT0 = 2, CL_FAULT1 = 3} irq_class_e;

  localparam logic [ADDR_W-1:0] OFF_SUMMARY = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_PRIO    = 12'h688;
  localparam logic [ADDR_W-1:0] OFF_BUSY    = 12'h690;

  // masked view of class c
  function automatic logic [ADDR_W-1:0] stat_addr(input int c);
    return 12'h004 + ADDR_W'(4 * c);
  endfunction

  // enable mask of class c
  function automatic logic [ADDR_W-1:0] mask_addr(input int c);
    return 12'h018 + ADDR_W'(4 * c);
  endfunction

  // sticky raw latch of class c (8-byte stride)
  function automatic logic [ADDR_W-1:0] raw_addr(input int c);
    return 12'h600 + ADDR_W'(8 * c);
  endfunction

  // next raw value: set beats write-1-clear
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] set,
                                              input logic [31:0] clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/dmairq_bank.sv
module dmairq_bank
  import dmairq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           mask_we_i,
  input  logic [NCH-1:0] mask_wdata_i,
  output logic [NCH-1:0] raw_o,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] masked_o
);
  logic [NCH-1:0] raw_q;
  logic [NCH-1:0] mask_q;
  logic [31:0]    raw_nxt;

  assign raw_nxt = sticky_next(32'(raw_q), 32'(set_i), 32'(clr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_nxt[NCH-1:0];
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
endmodule

// File: rtl/dmairq_summary.sv
module dmairq_summary #(
  parameter int NCLS = 4,
  parameter int NCH  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCLS-1:0][NCH-1:0]  masked_i,
  output logic [NCH-1:0]            summary_o,
  output logic                      irq_o
);
  logic irq_q;

  always_comb begin
    summary_o = '0;
    for (int c = 0; c < NCLS; c++) summary_o = summary_o | masked_i[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |summary_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dmairq_readmux.sv
module dmairq_readmux
  import dmairq_pkg::*;
#(
  parameter int NCLS   = 4,
  parameter int NCH    = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 32
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NCLS-1:0][NCH-1:0]  raw_i,
  input  logic [NCLS-1:0][NCH-1:0]  mask_i,
  input  logic [NCLS-1:0][NCH-1:0]  masked_i,
  input  logic [NCH-1:0]            summary_i,
  input  logic [NCH-1:0]            busy_i,
  input  logic [PRIO_W-1:0]         prio_i,
  output logic [DATA_W-1:0]         rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_SUMMARY) rdata_o[NCH-1:0] = summary_i;
    if (addr_i == OFF_BUSY)    rdata_o[NCH-1:0] = busy_i;
    if (addr_i == OFF_PRIO)    rdata_o[PRIO_W-1:0] = prio_i;
    for (int c = 0; c < NCLS; c++) begin
      if (addr_i == stat_addr(c)) rdata_o[NCH-1:0] = masked_i[c];
      if (addr_i == mask_addr(c)) rdata_o[NCH-1:0] = mask_i[c];
      if (addr_i == raw_addr(c))  rdata_o[NCH-1:0] = raw_i[c];
    end
  end
endmodule

// File: rtl/dmairq_aggr.sv
module dmairq_aggr
  import dmairq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    evt_chain_i,
  input  logic [NCH-1:0]    evt_node_i,
  input  logic [NCH-1:0]    evt_fault0_i,
  input  logic [NCH-1:0]    evt_fault1_i,
  input  logic [NCH-1:0]    ch_busy_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int NCLS = NCLASS;

  logic [NCLS-1:0][NCH-1:0] evt_all;
  logic [NCLS-1:0][NCH-1:0] clr_all;
  logic [NCLS-1:0][NCH-1:0] raw_all;
  logic [NCLS-1:0][NCH-1:0] mask_all;
  logic [NCLS-1:0][NCH-1:0] masked_all;
  logic [NCLS-1:0]          mask_we;
  logic [NCH-1:0]           summary;
  logic [PRIO_W-1:0]        prio_q;

  // named views for the checker
  logic [NCLS*NCH-1:0] evt_flat;
  logic [NCLS*NCH-1:0] raw_flat;

  assign evt_all[CL_CHAIN]  = evt_chain_i;
  assign evt_all[CL_NODE]   = evt_node_i;
  assign evt_all[CL_FAULT0] = evt_fault0_i;
  assign evt_all[CL_FAULT1] = evt_fault1_i;
  assign evt_flat = evt_all;
  assign raw_flat = raw_all;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign mask_we[c] = bus_wr_i && (bus_addr_i == mask_addr(c));
    assign clr_all[c] = (bus_wr_i && (bus_addr_i == raw_addr(c)))
                        ? bus_wdata_i[NCH-1:0] : '0;

    dmairq_bank #(.NCH(NCH)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (evt_all[c]),
      .clr_i        (clr_all[c]),
      .mask_we_i    (mask_we[c]),
      .mask_wdata_i (bus_wdata_i[NCH-1:0]),
      .raw_o        (raw_all[c]),
      .mask_o       (mask_all[c]),
      .masked_o     (masked_all[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else if (bus_wr_i && (bus_addr_i == OFF_PRIO)) prio_q <= bus_wdata_i[PRIO_W-1:0];
  end

  dmairq_summary #(.NCLS(NCLS), .NCH(NCH)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .masked_i  (masked_all),
    .summary_o (summary),
    .irq_o     (irq_o)
  );

  dmairq_readmux #(.NCLS(NCLS), .NCH(NCH), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_rd (
    .addr_i    (bus_addr_i),
    .raw_i     (raw_all),
    .mask_i    (mask_all),
    .masked_i  (masked_all),
    .summary_i (summary),
    .busy_i    (ch_busy_i),
    .prio_i    (prio_q),
    .rdata_o   (bus_rdata_o)
  );
endmodule

// File: rtl/dmairq_aggr_chk.sv
module dmairq_aggr_chk
  import dmairq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NCLASS*NCH-1:0] evt_flat,
  input logic [NCLASS*NCH-1:0] raw_flat,
  input logic [NCH-1:0]       mask_chain,
  input logic [NCH-1:0]       summary,
  input logic                 irq
);
  logic clr_chain_hit;
  assign clr_chain_hit = bus_wr && (bus_addr == raw_addr(0));

  // R1: every event bit is latched on the next edge
  p_event_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_flat) |=> ((raw_flat & $past(evt_flat)) == $past(evt_flat)));

  // R1: a raw bit never rises without its event
  p_no_spurious_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_flat & ~$past(raw_flat) & ~$past(evt_flat)) == '0));

  // R2: chain bits written as 1 without a colliding event are cleared
  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_chain_hit |=> ((raw_flat[NCH-1:0] & $past(bus_wdata[NCH-1:0])
                        & ~$past(evt_flat[NCH-1:0])) == '0));

  // R3: colliding set and clear leave the bit set
  p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_chain_hit && ((evt_flat[NCH-1:0] & bus_wdata[NCH-1:0]) != '0)) |=>
    ((raw_flat[NCH-1:0] & $past(evt_flat[NCH-1:0] & bus_wdata[NCH-1:0]))
      == $past(evt_flat[NCH-1:0] & bus_wdata[NCH-1:0])));

  // R5: chain mask only moves on a write to its own address
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == mask_addr(0))) |=> $stable(mask_chain));

  // R7: irq follows the summary by one cycle
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|summary) |=> irq);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|summary) |=> !irq);
endmodule

bind dmairq_aggr dmairq_aggr_chk #(.NCH(NCH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr_i),
  .bus_addr   (bus_addr_i),
  .bus_wdata  (bus_wdata_i),
  .evt_flat   (evt_flat),
  .raw_flat   (raw_flat),
  .mask_chain (mask_all[0]),
  .summary    (summary),
  .irq        (irq_o)
);

// File: tb/dmairq_aggr_bench.sv
module dmairq_aggr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0][N-1:0] ev = '0;
  logic [N-1:0]     busy = '0;
  logic             wr = 1'b0;
  logic [11:0]      addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dmairq_aggr u_dmairq_aggr (
    .clk(clk), .rst_n(rst_n),
    .evt_chain_i(ev[0]), .evt_node_i(ev[1]),
    .evt_fault0_i(ev[2]), .evt_fault1_i(ev[3]),
    .ch_busy_i(busy), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side address arithmetic
  function automatic logic [11:0] a_raw(int c);  return 12'h600 | 12'(c << 3); endfunction
  function automatic logic [11:0] a_mask(int c); return 12'h018 + 12'(c << 2); endfunction
  function automatic logic [11:0] a_stat(int c); return 12'h004 + 12'(c << 2); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int c, input logic [N-1:0] bits);
    @(negedge clk);
    ev[c] = bits;
    @(negedge clk);
    ev[c] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check("R9 irq", 32'(irq), 0);
    rd(12'h000, d); check("R9 summary", d, 0);
    rd(12'h688, d); check("R9 prio", d, 0);
    for (int c = 0; c < 4; c++) begin
      rd(a_raw(c), d);  check("R9 raw", d, 0);
      rd(a_mask(c), d); check("R9 mask", d, 0);
    end

    // per-class, per-channel sweep
    for (int c = 0; c < 4; c++) begin
      for (int n = 0; n < N; n++) begin
        logic [31:0] b;
        b = 32'(1) << n;
        pulse(c, b[N-1:0]);
        #1 check("R7 irq stays low while masked", 32'(irq), 0);
        rd(a_raw(c), d);            check("R1 raw set though masked", d, b);
        rd(a_raw((c + 1) % 4), d);  check("R11 other class untouched", d, 0);
        rd(a_stat(c), d);           check("R4 masked view with mask 0", d, 0);
        rd(12'h000, d);             check("R6 summary with mask 0", d, 0);
        bus_write(a_mask(c), b);
        rd(a_stat(c), d);           check("R4 masked view enabled", d, b);
        rd(12'h000, d);             check("R6 summary bit", d, b);
        check("R7 irq high", 32'(irq), 1);
        bus_write(a_raw(c), 0);
        rd(a_raw(c), d);            check("R2 write 0 keeps bit", d, b);
        bus_write(a_raw(c), ~b);
        rd(a_raw(c), d);            check("R2 other ones keep bit", d, b);
        bus_write(a_raw(c), b);
        #1 check("R7 irq falls one cycle late", 32'(irq), 1);
        @(negedge clk); #1 check("R7 irq low", 32'(irq), 0);
        rd(a_raw(c), d);            check("R2 bit cleared", d, 0);
        bus_write(a_mask(c), 0);
      end
    end

    // mixed pattern across classes
    begin
      logic [3:0][15:0] pat, msk;
      logic [31:0] sum;
      pat = {16'h8001, 16'h000F, 16'h0F00, 16'h00F0};
      msk = {16'h8000, 16'h0003, 16'h0000, 16'hFFFF};
      sum = 0;
      @(negedge clk);
      for (int c = 0; c < 4; c++) ev[c] = pat[c];
      @(negedge clk);
      ev = '0;
      for (int c = 0; c < 4; c++) bus_write(a_mask(c), 32'(msk[c]));
      for (int c = 0; c < 4; c++) begin
        rd(a_raw(c), d);  check("R11 pattern raw", d, 32'(pat[c]));
        rd(a_stat(c), d); check("R4 pattern masked", d, 32'(pat[c] & msk[c]));
        sum = sum | 32'(pat[c] & msk[c]);
      end
      rd(12'h000, d); check("R6 pattern summary", d, sum);
      check("R7 pattern irq", 32'(irq), 1);
      // R10: writes to read-only and unmapped addresses
      bus_write(12'h004, 32'hFFFF);
      bus_write(12'h000, 32'hFFFF);
      bus_write(12'h014, 32'hFFFF);
      rd(a_raw(0), d);  check("R10 raw after read-only write", d, 32'(pat[0]));
      rd(a_mask(1), d); check("R10 mask after unmapped write", d, 0);
      rd(12'h000, d);   check("R10 summary unchanged", d, sum);
      for (int c = 0; c < 4; c++) bus_write(a_raw(c), 32'hFFFF);
      for (int c = 0; c < 4; c++) bus_write(a_mask(c), 0);
      rd(12'h000, d); check("R2 all cleared", d, 0);
    end

    // R3 set beats clear
    pulse(0, 16'h0001);
    @(negedge clk);
    ev[0] = 16'h0010; wr = 1'b1; addr = a_raw(0); wdata = 32'h0011;
    @(negedge clk);
    ev[0] = '0; wr = 1'b0; wdata = '0;
    rd(a_raw(0), d); check("R3 set wins, other bit cleared", d, 32'h0010);
    bus_write(a_raw(0), 32'h0010);

    // R5 mask width and readback
    bus_write(a_mask(2), 32'hFFFF_FFFF);
    rd(a_mask(2), d); check("R5 mask truncated", d, 32'h0000_FFFF);
    bus_write(a_mask(3), 32'h0000_A5A5);
    rd(a_mask(3), d); check("R5 mask pattern", d, 32'h0000_A5A5);
    rd(a_mask(2), d); check("R5 neighbour mask kept", d, 32'h0000_FFFF);
    bus_write(a_mask(2), 0);
    bus_write(a_mask(3), 0);

    // R8 busy and priority
    busy = 16'h1234;
    rd(12'h690, d); check("R8 busy", d, 32'h1234);
    bus_write(12'h690, 32'hFFFF);
    busy = 16'h8001;
    rd(12'h690, d); check("R8 busy live after write", d, 32'h8001);
    bus_write(12'h688, 32'hDEAD_BEEF);
    rd(12'h688, d); check("R8 prio readback", d, 32'hDEAD_BEEF);
    bus_write(12'h688, 0);
    rd(12'h688, d); check("R8 prio equal", d, 0);

    // R10 unmapped reads
    rd(12'h014, d); check("R10 unmapped 014", d, 0);
    rd(12'h604, d); check("R10 unmapped 604", d, 0);
    rd(12'h7FC, d); check("R10 unmapped 7FC", d, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule